// File: doc/BRIEF.md
# Virtual Interrupt Recognition Unit

This block decides, at each instruction boundary, whether a guest takes an injected virtual maskable interrupt. On guest entry it captures a request context: a pending flag, a request priority, a task-priority threshold, a flag that bypasses the threshold, a vector, and the saved interrupt-shadow bit. While the guest runs, it combines that context with the live interrupt-enable flag, the global interrupt flag, the shadow state and any pending physical interrupt. It then either delivers the interrupt or asks for a guest exit when the virtual-interrupt intercept is on.

A small state machine with four states tracks where the guest is. `ST_HOST` is the idle host mode. `ST_GUEST` means the guest is running and checks are made at each boundary. `ST_DELIVER` is a one-cycle dispatch with the vector presented. `ST_EXIT_REQ` holds an exit request until the exit happens.

The transitions are:
- `T_ENTER`: HOST to GUEST on an entry load.
- `T_DISPATCH`: GUEST to DELIVER when the interrupt is eligible and the intercept is off.
- `T_INTERCEPT`: GUEST to EXIT_REQ when the interrupt is eligible and the intercept is on.
- `T_RESUME`: DELIVER to GUEST on the next cycle.
- `T_EXIT`: any guest state to HOST on a guest exit.

On exit, the pending flag and the shadow bit are reported on a one-cycle write-back strobe. The internal copies are then cleared.

Top module: `virq_recog_unit`

## Requirements
- R1: After reset the unit is in host mode and `take_virtual`, `take_exit`, `wb_valid` and `vector_out` are all 0.
- R2: In guest mode, a `boundary` pulse in a cycle where pending=1, priority > threshold, `if_flag`=1, `gif`=1, no shadow is active, `phys_pending`=0 and `vint_intercept`=0 makes `take_virtual` 1 for exactly the following cycle.
- R3: The priority test is strict. With the bypass flag clear, a priority equal to or below the threshold never produces `take_virtual` or `take_exit`.
- R4: With the bypass flag set, the priority test is skipped and the other conditions of R2 still apply.
- R5: While `take_virtual` is 1, `vector_out` equals the vector captured at entry. Otherwise `vector_out` is 0.
- R6: If `vint_intercept` is 1 where R2 would deliver, `take_exit` goes to 1 in the following cycle instead. It stays 1 until a `guest_exit` pulse, and boundaries in between deliver nothing.
- R7: Delivery clears the pending flag, so a later boundary delivers nothing and the next write-back reports pending=0. An intercept leaves the flag set.
- R8: `phys_pending`=1 at a boundary blocks both delivery and the intercept exit at that boundary.
- R9: A `guest_exit` pulse in any guest state makes `wb_valid` 1 for the next cycle, with `wb_pending` and `wb_shadow` carrying the values held at exit. The unit then returns to host mode, where boundaries deliver nothing and exit pulses are ignored.
- R10: An `if_rise` pulse (the guest set the interrupt-enable flag from 0 to 1) blocks delivery at the boundary in the same cycle and at the next boundary. Delivery is allowed again from the boundary after that. A shadow bit loaded at entry blocks the first boundary.
- R11: In guest mode, an `entry_load` pulse arriving with `guest_exit` in the same cycle is ignored and the exit is carried out.
- R12: Without a `boundary` pulse, neither `take_virtual` nor `take_exit` ever rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_load | input | 1 | Guest-entry pulse that captures the context |
| ld_pending | input | 1 | Pending flag to load |
| ld_prio | input | PRIO_W | Request priority to load |
| ld_thresh | input | PRIO_W | Task-priority threshold to load |
| ld_bypass | input | 1 | Skip-threshold flag to load |
| ld_vector | input | VEC_W | Vector to load |
| ld_shadow | input | 1 | Saved shadow bit to load |
| guest_exit | input | 1 | Guest-exit pulse |
| boundary | input | 1 | Instruction-boundary strobe |
| if_flag | input | 1 | Guest interrupt-enable flag |
| gif | input | 1 | Global interrupt flag |
| if_rise | input | 1 | Instruction set the interrupt-enable flag from 0 to 1 |
| phys_pending | input | 1 | Physical interrupt pending |
| vint_intercept | input | 1 | Virtual-interrupt intercept enable |
| take_virtual | output | 1 | Dispatch the virtual interrupt now |
| take_exit | output | 1 | Guest exit requested by the intercept |
| vector_out | output | VEC_W | Vector for dispatch |
| wb_valid | output | 1 | Write-back strobe after an exit |
| wb_pending | output | 1 | Pending flag written back |
| wb_shadow | output | 1 | Shadow bit written back |

## Verification
A stale pending flag or a wrong state shows up at the very next boundary, as a `take_virtual` or `take_exit` pulse one cycle later that the reference model does not expect, or as a missing one. A shadow bit that clears too early or too late moves delivery by exactly one boundary. A pending flag that is not cleared on dispatch shows in `wb_pending` one cycle after the following exit. Because the bench compares every output with a behavioural model on every clock, such a fault is reported within one or two cycles of the stimulus that exposes it.

// File: rtl/virq_pkg.sv
package virq_pkg;
    typedef enum logic [1:0] {
        ST_HOST     = 2'd0,
        ST_GUEST    = 2'd1,
        ST_DELIVER  = 2'd2,
        ST_EXIT_REQ = 2'd3
    } virq_state_e;
endpackage

// File: rtl/virq_ctx_regs.sv
module virq_ctx_regs #(
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              exit_en,
    input  logic              dispatch_clr,
    input  logic              ld_pending,
    input  logic [PRIO_W-1:0] ld_prio,
    input  logic [PRIO_W-1:0] ld_thresh,
    input  logic              ld_bypass,
    input  logic [VEC_W-1:0]  ld_vector,
    output logic              pend_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [PRIO_W-1:0] thresh_q,
    output logic              bypass_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic              wb_valid,
    output logic              wb_pending
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            prio_q     <= '0;
            thresh_q   <= '0;
            bypass_q   <= 1'b0;
            vec_q      <= '0;
            wb_valid   <= 1'b0;
            wb_pending <= 1'b0;
        end else begin
            wb_valid <= exit_en;
            if (exit_en) begin
                wb_pending <= pend_q;
                pend_q     <= 1'b0;
                bypass_q   <= 1'b0;
            end else if (load_en) begin
                pend_q   <= ld_pending;
                prio_q   <= ld_prio;
                thresh_q <= ld_thresh;
                bypass_q <= ld_bypass;
                vec_q    <= ld_vector;
            end else if (dispatch_clr) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R9: the write-back strobe lasts one cycle per exit
    a_r9_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);
endmodule

// File: rtl/virq_shadow.sv
module virq_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic ld_shadow,
    input  logic exit_en,
    input  logic track_en,
    input  logic if_rise,
    input  logic boundary,
    output logic shadow_block,
    output logic wb_shadow
);
    logic shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q  <= 1'b0;
            wb_shadow <= 1'b0;
        end else if (exit_en) begin
            wb_shadow <= shadow_q;
            shadow_q  <= 1'b0;
        end else if (load_en) begin
            shadow_q <= ld_shadow;
        end else if (track_en) begin
            if (if_rise)
                shadow_q <= 1'b1;
            else if (boundary)
                shadow_q <= 1'b0;
        end
    end

    assign shadow_block = shadow_q | if_rise;

    // R10: a rise in the enable flag leaves the next cycle shadowed
    a_r10_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (if_rise && track_en && !exit_en) |=> shadow_block);
endmodule

// File: rtl/virq_gate.sv
module virq_gate #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] thresh,
    input  logic              bypass,
    input  logic              if_flag,
    input  logic              gif,
    input  logic              shadow_block,
    input  logic              phys_pending,
    output logic              eligible
);
    logic prio_ok;
    logic unmasked;

    always_comb begin
        prio_ok  = bypass || (prio > thresh);
        unmasked = if_flag && gif && !shadow_block;
        eligible = pend && prio_ok && unmasked && !phys_pending;
    end

    // R3: with the threshold applied, equal priority never qualifies
    a_r3_strict: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && prio == thresh) |-> !eligible);
    // R8: a physical interrupt always masks the virtual one
    a_r8_phys_wins: assert property (@(posedge clk) disable iff (!rst_n)
        phys_pending |-> !eligible);
endmodule

// File: rtl/virq_fsm.sv
module virq_fsm
    import virq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_load,
    input  logic             guest_exit,
    input  logic             boundary,
    input  logic             eligible,
    input  logic             intercept,
    input  logic [VEC_W-1:0] vec,
    output logic             do_load,
    output logic             do_exit,
    output logic             do_dispatch,
    output logic             in_guest,
    output logic             take_virtual,
    output logic             take_exit,
    output logic [VEC_W-1:0] vector_out
);
    virq_state_e state_q, state_d;
    logic        fire;

    always_comb begin
        fire        = (state_q == ST_GUEST) && boundary && eligible;
        do_exit     = guest_exit && (state_q != ST_HOST);
        do_load     = entry_load && (state_q == ST_HOST);
        do_dispatch = fire && !intercept && !do_exit;
        in_guest    = (state_q != ST_HOST);
        state_d     = state_q;
        unique case (state_q)
            ST_HOST:     if (do_load) state_d = ST_GUEST;
            ST_GUEST: begin
                if (do_exit)            state_d = ST_HOST;
                else if (do_dispatch)   state_d = ST_DELIVER;
                else if (fire)          state_d = ST_EXIT_REQ;
            end
            ST_DELIVER:  state_d = do_exit ? ST_HOST : ST_GUEST;
            ST_EXIT_REQ: if (do_exit) state_d = ST_HOST;
            default:     state_d = ST_HOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOST;
        else        state_q <= state_d;
    end

    always_comb begin
        take_virtual = (state_q == ST_DELIVER);
        take_exit    = (state_q == ST_EXIT_REQ);
        vector_out   = take_virtual ? vec : '0;
    end

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_virtual, take_exit}));
    // R6: the exit request is held until the exit arrives
    a_r6_exit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exit && !guest_exit) |=> take_exit);
    // R12: actions start only from a boundary
    a_r12_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(take_virtual) || $rose(take_exit)) |-> $past(boundary));
    // R9: after an exit the unit is back in host mode
    a_r9_host_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        do_exit |=> !in_guest);
endmodule

// File: rtl/virq_recog_unit.sv
module virq_recog_unit #(
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_load,
    input  logic              ld_pending,
    input  logic [PRIO_W-1:0] ld_prio,
    input  logic [PRIO_W-1:0] ld_thresh,
    input  logic              ld_bypass,
    input  logic [VEC_W-1:0]  ld_vector,
    input  logic              ld_shadow,
    input  logic              guest_exit,
    input  logic              boundary,
    input  logic              if_flag,
    input  logic              gif,
    input  logic              if_rise,
    input  logic              phys_pending,
    input  logic              vint_intercept,
    output logic              take_virtual,
    output logic              take_exit,
    output logic [VEC_W-1:0]  vector_out,
    output logic              wb_valid,
    output logic              wb_pending,
    output logic              wb_shadow
);
    logic              do_load, do_exit, do_dispatch, in_guest;
    logic              pend_q, bypass_q, shadow_block, eligible;
    logic [PRIO_W-1:0] prio_q, thresh_q;
    logic [VEC_W-1:0]  vec_q;

    virq_ctx_regs #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .load_en(do_load), .exit_en(do_exit), .dispatch_clr(do_dispatch),
        .ld_pending(ld_pending), .ld_prio(ld_prio), .ld_thresh(ld_thresh),
        .ld_bypass(ld_bypass), .ld_vector(ld_vector),
        .pend_q(pend_q), .prio_q(prio_q), .thresh_q(thresh_q),
        .bypass_q(bypass_q), .vec_q(vec_q),
        .wb_valid(wb_valid), .wb_pending(wb_pending)
    );

    virq_shadow u_shadow (
        .clk(clk), .rst_n(rst_n),
        .load_en(do_load), .ld_shadow(ld_shadow), .exit_en(do_exit),
        .track_en(in_guest), .if_rise(if_rise), .boundary(boundary),
        .shadow_block(shadow_block), .wb_shadow(wb_shadow)
    );

    virq_gate #(.PRIO_W(PRIO_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .pend(pend_q), .prio(prio_q), .thresh(thresh_q), .bypass(bypass_q),
        .if_flag(if_flag), .gif(gif), .shadow_block(shadow_block),
        .phys_pending(phys_pending), .eligible(eligible)
    );

    virq_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .entry_load(entry_load), .guest_exit(guest_exit), .boundary(boundary),
        .eligible(eligible), .intercept(vint_intercept), .vec(vec_q),
        .do_load(do_load), .do_exit(do_exit), .do_dispatch(do_dispatch),
        .in_guest(in_guest), .take_virtual(take_virtual),
        .take_exit(take_exit), .vector_out(vector_out)
    );

    // R7: the pending copy is already clear while dispatch is shown
    a_r7_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        take_virtual |-> !pend_q);
    // R10: no delivery follows a shadowed boundary
    a_r10_no_shadow_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_virtual) |-> !$past(shadow_block));
endmodule

// File: tb/virq_recog_unit_bench.sv
`timescale 1ns/1ps
module virq_recog_unit_bench;
    localparam int PW = 4;
    localparam int VW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic entry_load = 0, ld_pending = 0, ld_bypass = 0, ld_shadow = 0;
    logic [PW-1:0] ld_prio = 0, ld_thresh = 0;
    logic [VW-1:0] ld_vector = 0;
    logic guest_exit = 0, boundary = 0, if_flag = 0, gif = 0, if_rise = 0;
    logic phys_pending = 0, vint_intercept = 0;
    logic take_virtual, take_exit, wb_valid, wb_pending, wb_shadow;
    logic [VW-1:0] vector_out;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    virq_recog_unit #(.PRIO_W(PW), .VEC_W(VW)) u_virq_recog_unit (
        .clk(clk), .rst_n(rst_n), .entry_load(entry_load),
        .ld_pending(ld_pending), .ld_prio(ld_prio), .ld_thresh(ld_thresh),
        .ld_bypass(ld_bypass), .ld_vector(ld_vector), .ld_shadow(ld_shadow),
        .guest_exit(guest_exit), .boundary(boundary), .if_flag(if_flag),
        .gif(gif), .if_rise(if_rise), .phys_pending(phys_pending),
        .vint_intercept(vint_intercept), .take_virtual(take_virtual),
        .take_exit(take_exit), .vector_out(vector_out), .wb_valid(wb_valid),
        .wb_pending(wb_pending), .wb_shadow(wb_shadow)
    );

    // behavioural reference model
    bit m_guest = 0, m_deliver = 0, m_xreq = 0;
    bit m_pend = 0, m_byp = 0, m_shad = 0;
    int m_prio = 0, m_thr = 0, m_vec = 0;
    bit m_wbv = 0, m_wbp = 0, m_wbs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_guest = 0; m_deliver = 0; m_xreq = 0; m_pend = 0; m_byp = 0;
            m_shad = 0; m_prio = 0; m_thr = 0; m_vec = 0;
            m_wbv = 0; m_wbp = 0; m_wbs = 0;
        end else begin
            bit active;
            bit elig;
            active = m_guest || m_deliver || m_xreq;
            elig = m_pend && (m_byp || m_prio > m_thr) && if_flag && gif
                   && !(m_shad || if_rise) && !phys_pending;
            m_wbv = 0;
            if (guest_exit && active) begin
                m_wbv = 1; m_wbp = m_pend; m_wbs = m_shad;
                m_pend = 0; m_byp = 0; m_shad = 0;
                m_guest = 0; m_deliver = 0; m_xreq = 0;
            end else if (!active) begin
                if (entry_load) begin
                    m_pend = ld_pending; m_prio = ld_prio; m_thr = ld_thresh;
                    m_byp = ld_bypass; m_vec = ld_vector; m_shad = ld_shadow;
                    m_guest = 1;
                end
            end else begin
                if (m_deliver) begin
                    m_deliver = 0; m_guest = 1;
                end else if (m_guest && boundary && elig) begin
                    m_guest = 0;
                    if (vint_intercept) m_xreq = 1;
                    else begin m_deliver = 1; m_pend = 0; end
                end
                if (if_rise) m_shad = 1;
                else if (boundary) m_shad = 0;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("take_virtual", take_virtual, m_deliver);
        chk("take_exit", take_exit, m_xreq);
        chk("vector_out", vector_out, m_deliver ? m_vec : 0);
        chk("wb_valid", wb_valid, m_wbv);
        if (m_wbv) begin
            chk("wb_pending", wb_pending, m_wbp);
            chk("wb_shadow", wb_shadow, m_wbs);
        end
    endtask

    // one clock: inputs already set at negedge, pulses dropped afterwards
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        entry_load = 0; guest_exit = 0; boundary = 0; if_rise = 0;
    endtask

    task automatic enter(input bit p, input int pr, input int th, input bit by,
                         input int v, input bit sh);
        entry_load = 1; ld_pending = p; ld_prio = pr[PW-1:0];
        ld_thresh = th[PW-1:0]; ld_bypass = by; ld_vector = v[VW-1:0];
        ld_shadow = sh;
        cyc();
    endtask

    task automatic leave();
        guest_exit = 1; cyc(); cyc();
    endtask

    task automatic bnd();
        boundary = 1; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        tag = "R1";
        chk("reset take_virtual", take_virtual, 0);
        chk("reset take_exit", take_exit, 0);
        chk("reset wb_valid", wb_valid, 0);
        chk("reset vector_out", vector_out, 0);
        rst_n = 1;
        cyc();

        tag = "R2"; if_flag = 1; gif = 1;
        enter(1, 5, 3, 0, 8'h41, 0);
        bnd();
        tag = "R5"; chk("direct vector", vector_out, 8'h41);
        cyc();
        tag = "R7"; bnd(); cyc();
        tag = "R9"; guest_exit = 1; cyc();
        chk("direct wb_pending after delivery", wb_pending, 0);
        cyc(); bnd(); guest_exit = 1; cyc();

        tag = "R3"; enter(1, 3, 3, 0, 8'h22, 0); bnd(); cyc();
        chk("direct equal priority", take_virtual, 0);
        leave();
        enter(1, 2, 9, 0, 8'h23, 0); bnd(); cyc(); leave();
        tag = "R4"; enter(1, 2, 9, 1, 8'h24, 0); bnd();
        chk("direct bypass take", take_virtual, 1);
        cyc(); leave();

        tag = "R6"; vint_intercept = 1;
        enter(1, 7, 1, 0, 8'h30, 0); bnd();
        chk("direct exit req", take_exit, 1);
        bnd(); bnd(); guest_exit = 1; cyc();
        chk("direct wb_pending kept", wb_pending, 1);
        cyc(); vint_intercept = 0;

        tag = "R8"; enter(1, 7, 1, 0, 8'h31, 0);
        phys_pending = 1; bnd(); cyc();
        vint_intercept = 1; bnd(); cyc(); vint_intercept = 0;
        gif = 0; phys_pending = 0; bnd(); cyc();
        gif = 1; if_flag = 0; bnd(); cyc();
        if_flag = 1; bnd(); cyc(); leave();

        tag = "R10"; enter(1, 9, 0, 0, 8'h55, 1); bnd(); cyc();
        bnd(); cyc(); leave();
        enter(1, 9, 0, 0, 8'h56, 0);
        if_rise = 1; boundary = 1; cyc(); bnd(); cyc(); bnd(); cyc();
        enter(1, 9, 0, 0, 8'h57, 0); if_rise = 1; cyc(); guest_exit = 1; cyc();
        chk("direct wb_shadow", wb_shadow, 1);
        cyc();

        tag = "R11"; enter(1, 9, 0, 0, 8'h60, 0);
        entry_load = 1; guest_exit = 1; ld_vector = 8'h61; cyc(); cyc();
        bnd(); cyc();

        tag = "R12"; enter(1, 9, 0, 0, 8'h70, 0);
        repeat (6) cyc();
        guest_exit = 1; cyc(); cyc();

        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            entry_load = ($urandom % 8) == 0;
            guest_exit = ($urandom % 10) == 0;
            boundary = ($urandom % 2) == 0;
            if_rise = ($urandom % 6) == 0;
            if_flag = ($urandom % 5) != 0;
            gif = ($urandom % 6) != 0;
            phys_pending = ($urandom % 7) == 0;
            vint_intercept = ($urandom % 4) == 0;
            ld_pending = ($urandom % 4) != 0;
            ld_prio = PW'($urandom); ld_thresh = PW'($urandom);
            ld_bypass = ($urandom % 4) == 0; ld_shadow = ($urandom % 5) == 0;
            ld_vector = VW'($urandom);
            cyc();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule